// File: doc/BRIEF.md
# Chip-Wide Sleep-All Controller

This block coordinates the entry into and exit from a whole-chip heavy sleep. It holds a bank of per-peripheral sleep-enable registers and a small system sleep-control register with two bits: heavy and all. When the all bit is set and the processor raises its deep-sleep trigger, the controller does three things. It copies every sleep-enable register into a shadow store, drives every sleep-enable bit to 1, and then drains.

While it drains, the controller waits until no peripheral whose sleep enable is set still requests its clock. Only then does it report that the chip is sleeping. A wake event ends the sleep: the shadow copies go back into the live registers in one cycle and the sleeping status drops in that same cycle. A wake that arrives during the drain aborts the entry and restores at once.

Software owns the control register. The hardware never clears it, so software writes it back to 0 after resume. Between the save and the restore, software writes to the sleep-enable registers are dropped.

Top module: `sleep_all_ctrl`

## Requirements
- R1: A write on the control port stores bit 0 as the heavy bit and bit 1 as the all bit. Both show on their outputs on the cycle after the write.
- R2: When the all bit is 1, the controller is idle and the trigger is sampled high, two things happen on the next cycle: every sleep-enable output bit reads 1, and the prior values are kept for restore.
- R3: A trigger while the all bit is 0 has no effect. The sleep-enable outputs keep their values and sleeping stays 0.
- R4: While draining, sleeping stays 0 as long as any clock-request bit whose sleep enable is 1 is set. Sleeping rises on the cycle after the edge at which all such bits are sampled 0.
- R5: A wake while sleeping restores every sleep-enable register to its value before the save, and deasserts sleeping, both on the next cycle.
- R6: A wake during the drain aborts the entry. The saved values are restored on the next cycle and sleeping never asserts.
- R7: When the controller is idle, a sleep-enable write to index k (0 to NUM_REGS-1) appears in output slice k on the next cycle. Writes made between the save and the restore are ignored.
- R8: After reset, all sleep-enable bits, the heavy bit, the all bit and sleeping are 0.
- R9: Sleep entry and wake leave the heavy and all bits unchanged. Only a control write alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 heavy, bit 1 all |
| cpu_sleep_req | input | 1 | Processor deep-sleep trigger |
| wake | input | 1 | Wake event |
| se_wr | input | 1 | Sleep-enable register write strobe |
| se_addr | input | $clog2(NUM_REGS) | Sleep-enable register index |
| se_wdata | input | REG_W | Sleep-enable write data |
| clk_req | input | NUM_REGS*REG_W | Peripheral clock requests, register k in slice k |
| se_out | output | NUM_REGS*REG_W | Live sleep enables, register k in slice k |
| heavy | output | 1 | Heavy-sleep control bit |
| sleep_all | output | 1 | Sleep-all control bit |
| sleeping | output | 1 | Chip is in sleep |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. The save-and-force follows the sampled trigger by one edge, sleeping follows the edge at which the last request clears by one edge, and the restore follows the wake by one edge. The bench drives inputs just after a falling edge and checks just before the next one, so each check sees the state after a single rising edge. For the negative cases it also holds clock requests for several cycles and confirms that sleeping stays low on each of them.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SLEEP = 2'd2
  } sac_state_e;
endpackage

// File: rtl/sac_se_bank.sv
module sac_se_bank #(
  parameter int NREG = 5,
  parameter int W    = 32,
  parameter int AW   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              save,
  input  logic              restore,
  input  logic              lock,
  output logic [NREG*W-1:0] se_flat
);
  logic [W-1:0] live_q   [NREG];
  logic [W-1:0] shadow_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        live_q[i]   <= '0;
        shadow_q[i] <= '0;
      end else if (save) begin
        shadow_q[i] <= live_q[i];
        live_q[i]   <= '1;
      end else if (restore) begin
        live_q[i]   <= shadow_q[i];
      end else if (wr_en && !lock && wr_addr == AW'(i)) begin
        live_q[i]   <= wr_data;
      end
    end
    assign se_flat[i*W +: W] = live_q[i];

    // R2: save forces every bit high
    p_force_r2: assert property (@(posedge clk) disable iff (rst)
      save |=> (live_q[i] == '1));
    // R5 / R6: restore brings back the shadow copy
    p_restore_r5: assert property (@(posedge clk) disable iff (rst)
      restore |=> (live_q[i] == $past(shadow_q[i])));
    // R7: locked registers ignore writes
    p_lock_r7: assert property (@(posedge clk) disable iff (rst)
      (lock && !restore) |=> $stable(live_q[i]));
  end
endmodule

// File: rtl/sac_seq.sv
module sac_seq
  import sac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic trig,
  input  logic wake,
  input  logic busy,
  output logic save,
  output logic restore,
  output logic lock,
  output logic sleeping
);
  sac_state_e state_q;
  logic       sleeping_q;

  assign save     = (state_q == ST_IDLE) && arm && trig;
  assign restore  = (state_q != ST_IDLE) && wake;
  assign lock     = (state_q != ST_IDLE);
  assign sleeping = sleeping_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sleeping_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  if (save) state_q <= ST_DRAIN;
        ST_DRAIN: begin
          if (wake) begin
            state_q <= ST_IDLE;
          end else if (!busy) begin
            state_q    <= ST_SLEEP;
            sleeping_q <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            state_q    <= ST_IDLE;
            sleeping_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: sleep is entered only with no outstanding clock request
  p_sleep_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sleeping_q) |-> $past(!busy));
  // R5: wake leaves sleep on the next cycle
  p_wake_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (sleeping_q && wake) |=> !sleeping_q);
  // R6: wake during drain aborts without sleeping
  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN && wake) |=> (!sleeping_q && state_q == ST_IDLE));
endmodule

// File: rtl/sleep_all_ctrl.sv
module sleep_all_ctrl #(
  parameter int NUM_REGS = 5,
  parameter int REG_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ctl_wr,
  input  logic [1:0]                  ctl_wdata,
  input  logic                        cpu_sleep_req,
  input  logic                        wake,
  input  logic                        se_wr,
  input  logic [$clog2(NUM_REGS)-1:0] se_addr,
  input  logic [REG_W-1:0]            se_wdata,
  input  logic [NUM_REGS*REG_W-1:0]   clk_req,
  output logic [NUM_REGS*REG_W-1:0]   se_out,
  output logic                        heavy,
  output logic                        sleep_all,
  output logic                        sleeping
);
  localparam int AW = $clog2(NUM_REGS);

  logic heavy_q, all_q;
  logic save, restore, lock, busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      heavy_q <= 1'b0;
      all_q   <= 1'b0;
    end else if (ctl_wr) begin
      heavy_q <= ctl_wdata[0];
      all_q   <= ctl_wdata[1];
    end
  end
  assign heavy     = heavy_q;
  assign sleep_all = all_q;

  assign busy = |(clk_req & se_out);

  sac_se_bank #(.NREG(NUM_REGS), .W(REG_W), .AW(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (se_wr),
    .wr_addr (se_addr),
    .wr_data (se_wdata),
    .save    (save),
    .restore (restore),
    .lock    (lock),
    .se_flat (se_out)
  );

  sac_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .arm      (all_q),
    .trig     (cpu_sleep_req),
    .wake     (wake),
    .busy     (busy),
    .save     (save),
    .restore  (restore),
    .lock     (lock),
    .sleeping (sleeping)
  );

  // R9: control bits move only on a control write
  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable({heavy_q, all_q}));
  // R3: no arming, no sleep
  p_unarmed_r3: assert property (@(posedge clk) disable iff (rst)
    (!all_q && !sleeping) |=> !sleeping);
endmodule

// File: tb/sim_sleep_all_ctrl.sv
module sim_sleep_all_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;
  localparam int W  = 32;

  logic clk = 1'b0;
  logic rst;
  logic ctl_wr = 1'b0;
  logic [1:0] ctl_wdata = '0;
  logic cpu_sleep_req = 1'b0;
  logic wake = 1'b0;
  logic se_wr = 1'b0;
  logic [2:0] se_addr = '0;
  logic [W-1:0] se_wdata = '0;
  logic [NR*W-1:0] clk_req = '0;
  logic [NR*W-1:0] se_out;
  logic heavy, sleep_all, sleeping;

  int checks = 0;
  int errors = 0;
  logic [NR*W-1:0] exp_se = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_all_ctrl #(.NUM_REGS(NR), .REG_W(W)) u0 (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cpu_sleep_req(cpu_sleep_req), .wake(wake), .se_wr(se_wr),
    .se_addr(se_addr), .se_wdata(se_wdata), .clk_req(clk_req),
    .se_out(se_out), .heavy(heavy), .sleep_all(sleep_all), .sleeping(sleeping)
  );

  task automatic chk(input string req, input logic [NR*W-1:0] act, input logic [NR*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [1:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; tick(); ctl_wr = 1'b0;
  endtask

  task automatic wr_se(input int k, input logic [W-1:0] v);
    se_wr = 1'b1; se_addr = 3'(k); se_wdata = v; tick(); se_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    cpu_sleep_req = 1'b1; tick(); cpu_sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(); wake = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 se", se_out, '0);
    chk("R8 ctl", {heavy, sleep_all}, 2'b00);
    chk("R8 sleeping", sleeping, 1'b0);
  endtask

  task automatic t_ctl();
    wr_ctl(2'b01);
    chk("R1 heavy only", {sleep_all, heavy}, 2'b01);
    wr_ctl(2'b10);
    chk("R1 all only", {sleep_all, heavy}, 2'b10);
    wr_ctl(2'b00);
    chk("R1 cleared", {sleep_all, heavy}, 2'b00);
  endtask

  task automatic t_idle_write();
    for (int k = 0; k < NR; k++) begin
      logic [W-1:0] v;
      v = 32'h1234_0000 ^ (32'h0101_0101 * (k + 1)) ^ (32'h8000_0000 >> k);
      wr_se(k, v);
      exp_se[k*W +: W] = v;
      chk("R7 idle write", se_out, exp_se);
    end
  endtask

  task automatic t_no_arm();
    pulse_trig();
    chk("R3 se unchanged", se_out, exp_se);
    repeat (3) tick();
    chk("R3 no sleep", sleeping, 1'b0);
  endtask

  task automatic t_full_cycle();
    wr_ctl(2'b11);
    clk_req = '0;
    clk_req[2*W + 3] = 1'b1;
    exp_se[2*W + 3] = 1'b0;
    wr_se(2, exp_se[2*W +: W]);
    chk("R7 write before arm", se_out, exp_se);
    pulse_trig();
    chk("R2 forced ones", se_out, '1);
    wr_se(1, 32'h0);
    chk("R7 write ignored while locked", se_out, '1);
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R4 held by request", sleeping, 1'b0);
    end
    clk_req = '0;
    tick();
    chk("R4 sleeping", sleeping, 1'b1);
    chk("R9 ctl kept in sleep", {heavy, sleep_all}, 2'b11);
    tick();
    chk("R4 still sleeping", sleeping, 1'b1);
    pulse_wake();
    chk("R5 restored", se_out, exp_se);
    chk("R5 awake", sleeping, 1'b0);
    chk("R9 ctl kept after wake", {heavy, sleep_all}, 2'b11);
    wr_ctl(2'b00);
  endtask

  task automatic t_abort();
    wr_ctl(2'b10);
    clk_req = '0;
    clk_req[4*W] = 1'b1;
    pulse_trig();
    chk("R2 forced before abort", se_out, '1);
    pulse_wake();
    chk("R6 restored on abort", se_out, exp_se);
    chk("R6 no sleep", sleeping, 1'b0);
    clk_req = '0;
    repeat (3) tick();
    chk("R6 stays awake", sleeping, 1'b0);
    wr_ctl(2'b00);
    wr_se(0, 32'hCAFE_F00D);
    exp_se[0 +: W] = 32'hCAFE_F00D;
    chk("R7 write after restore", se_out, exp_se);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_ctl();
    t_idle_write();
    t_no_arm();
    t_full_cycle();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule